// File: doc/BRIEF.md
# PCI Delayed-Read Lifetime Manager

This block sits on the target side of a PCI bridge and handles reads from an external master that the internal fabric cannot answer quickly. A read to a free buffer starts an internal fetch. If the fetch completes within a fixed first-data window, the data goes straight back to the master. If it does not, the master is told to retry. The address is then recorded, and the fetched data is reserved for that address for a programmable number of PCI clocks. When the master repeats the read in that period, it is served at once. Reads to any other address are retried while the reservation stands.

Exactly one delayed read can be tracked at a time. The reservation period comes from a 16-bit lifetime register. The hold timer starts in the cycle the retry is presented. When the timer runs out, any held data is thrown away. If the fetch is still outstanding at that point, the block waits for the late completion, discards it and then frees the buffer.

The data interfaces follow valid/ready rules:
- **Request:** a request is held on `rq_valid`/`rq_addr` until `rq_ready` is seen high at a clock edge. `rq_ready` stays low from acceptance until the response has been taken.
- **Response:** `rsp_valid`, `rsp_retry` and `rsp_data` are held unchanged until `rsp_ready`.
- **Fetch:** the fetch request is held until `fch_ready`.
- **Completion:** `cpl_valid` is a single-cycle strobe and cannot be back-pressured.

Top module: `drl_delayed_read`

## Requirements
- R1: After reset `life_q` is 0x8000. A cycle with `life_we` high loads `life_wdata` into `life_q` from the next cycle on.
- R2: A read accepted while the buffer is free raises `fch_valid` in the next cycle with `fch_addr` equal to the request address. Both are held until the cycle in which `fch_ready` is high.
- R3: A request accepted at the edge ending cycle t has a first-data window of cycles t+1 to t+16. A `cpl_valid` in any of those cycles produces a data response (`rsp_retry`=0, `rsp_data`=`cpl_data`) in the following cycle, and nothing is reserved.
- R4: With no completion inside the window, a retry response (`rsp_retry`=1, `rsp_data`=0) appears in cycle t+17. The hold timer is loaded in that cycle with the current `life_q`.
- R5: A read whose address matches held, completed data is answered in the next cycle with that data and `rsp_retry`=0. No fetch is issued, and the buffer becomes free.
- R6: While the buffer is occupied, a read to any other address is answered with a retry in the next cycle and issues no fetch.
- R7: A read to the reserved address before its completion has arrived is answered with a retry and issues no fetch.
- R8: The reservation covers cycles T to T+L, where T is the retry cycle and L the loaded lifetime. After that the data is discarded and the next read starts a new fetch. A lifetime of zero therefore frees the buffer one clock after the retry.
- R9: If the reservation ends before the completion arrives, every read is retried until that completion comes. The late data is then discarded and the buffer is free.
- R10: A response stays valid with unchanged `rsp_retry` and `rsp_data` while `rsp_ready` is low, and no request is accepted meanwhile.
- R11: Writing the lifetime register while a reservation is running does not change that reservation; only later loads use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_valid | input | 1 | Master read request present |
| rq_ready | output | 1 | Block can accept a request |
| rq_addr | input | 32 | Read address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_retry | output | 1 | 1 = retry, 0 = data |
| rsp_data | output | 32 | Read data (0 on retry) |
| fch_valid | output | 1 | Internal fetch request |
| fch_ready | input | 1 | Fetch request accepted |
| fch_addr | output | 32 | Fetch address |
| cpl_valid | input | 1 | Fetch completion strobe |
| cpl_data | input | 32 | Completion data |
| life_we | input | 1 | Lifetime register write enable |
| life_wdata | input | 16 | Lifetime write value |
| life_q | output | 16 | Lifetime register value |

## Verification
The hardest situations to reach are the ones where the end of the reservation meets a completion. One is the completion arriving in the same cycle as expiry with a zero lifetime. The other is the completion arriving only after expiry, which forces the drain behaviour. The stimulus gets there by programming short lifetimes and by holding back the completion: either by exactly one cycle past the 16-cycle window, or indefinitely until the bench releases it by hand. A behavioural model in the bench follows every clock, so the exact cycle of expiry and of each retry is checked.

// File: rtl/drl_pkg.sv
package drl_pkg;

  // request-side sequencing
  typedef enum logic [1:0] {
    C_IDLE,
    C_WAIT,
    C_RESP
  } ctl_e;

  // delayed-read buffer occupancy
  typedef enum logic [1:0] {
    B_FREE,
    B_WAITD,
    B_HELD,
    B_DRAIN
  } buf_e;

endpackage

// File: rtl/drl_life_reg.sv
module drl_life_reg #(
  parameter int          LW       = 16,
  parameter int unsigned LIFE_RST = 32'h0000_8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [LW-1:0] wdata,
  output logic [LW-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= LW'(LIFE_RST);
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/drl_window.sv
module drl_window #(
  parameter int DEADLINE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic last
);

  localparam int CW = (DEADLINE > 1) ? $clog2(DEADLINE) : 1;

  logic [CW-1:0] cnt_q;

  assign last = run && (cnt_q == CW'(DEADLINE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= '0;
    else if (run && !last)  cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/drl_hold_timer.sv
module drl_hold_timer #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] load_val,
  input  logic          run,
  output logic          zero,
  output logic [LW-1:0] value
);

  always_ff @(posedge clk) begin
    if (!rst_n)                    value <= '0;
    else if (load)                 value <= load_val;
    else if (run && value != '0)   value <= value - LW'(1);
  end

  assign zero = (value == '0);

endmodule

// File: rtl/drl_fetch_port.sv
module drl_fetch_port #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] addr,
  output logic          fch_valid,
  input  logic          fch_ready,
  output logic [AW-1:0] fch_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fch_valid <= 1'b0;
      fch_addr  <= '0;
    end else if (issue) begin
      fch_valid <= 1'b1;
      fch_addr  <= addr;
    end else if (fch_ready) begin
      fch_valid <= 1'b0;
    end
  end

  p_fch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fch_valid && !fch_ready |=> fch_valid && $stable(fch_addr));

endmodule

// File: rtl/drl_delayed_read.sv
module drl_delayed_read
  import drl_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter int          LW       = 16,
  parameter int          DEADLINE = 16,
  parameter int unsigned LIFE_RST = 32'h0000_8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rq_valid,
  output logic          rq_ready,
  input  logic [AW-1:0] rq_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_retry,
  output logic [DW-1:0] rsp_data,
  output logic          fch_valid,
  input  logic          fch_ready,
  output logic [AW-1:0] fch_addr,
  input  logic          cpl_valid,
  input  logic [DW-1:0] cpl_data,
  input  logic          life_we,
  input  logic [LW-1:0] life_wdata,
  output logic [LW-1:0] life_q
);

  ctl_e          ctl_q;
  buf_e          buf_q;
  logic [AW-1:0] raddr_q;
  logic [AW-1:0] baddr_q;
  logic [DW-1:0] bdata_q;
  logic          rsp_valid_q;
  logic          rsp_retry_q;
  logic [DW-1:0] rsp_data_q;

  logic          accept;
  logic          hit;
  logic          issue;
  logic          win_last;
  logic          timeout;
  logic          timer_run;
  logic          timer_zero;
  logic          expire;
  logic [LW-1:0] timer_val;

  assign rq_ready  = (ctl_q == C_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_retry = rsp_retry_q;
  assign rsp_data  = rsp_data_q;

  assign accept    = rq_valid && rq_ready;
  assign hit       = accept && (buf_q == B_HELD) && (rq_addr == baddr_q);
  assign issue     = accept && (buf_q == B_FREE);
  assign timeout   = (ctl_q == C_WAIT) && win_last && !cpl_valid;
  assign timer_run = (buf_q == B_WAITD) || (buf_q == B_HELD);
  assign expire    = timer_run && timer_zero;

  drl_life_reg #(.LW(LW), .LIFE_RST(LIFE_RST)) u_life (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (life_we),
    .wdata (life_wdata),
    .q     (life_q)
  );

  drl_window #(.DEADLINE(DEADLINE)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .start (issue),
    .run   (ctl_q == C_WAIT),
    .last  (win_last)
  );

  drl_hold_timer #(.LW(LW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timeout),
    .load_val (life_q),
    .run      (timer_run),
    .zero     (timer_zero),
    .value    (timer_val)
  );

  drl_fetch_port #(.AW(AW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .addr      (rq_addr),
    .fch_valid (fch_valid),
    .fch_ready (fch_ready),
    .fch_addr  (fch_addr)
  );

  // request / response sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q       <= C_IDLE;
      raddr_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_retry_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      case (ctl_q)
        C_IDLE: begin
          if (accept) begin
            raddr_q <= rq_addr;
            if (buf_q == B_FREE) begin
              ctl_q <= C_WAIT;
            end else begin
              ctl_q       <= C_RESP;
              rsp_valid_q <= 1'b1;
              rsp_retry_q <= !hit;
              rsp_data_q  <= hit ? bdata_q : '0;
            end
          end
        end
        C_WAIT: begin
          if (cpl_valid) begin
            ctl_q       <= C_RESP;
            rsp_valid_q <= 1'b1;
            rsp_retry_q <= 1'b0;
            rsp_data_q  <= cpl_data;
          end else if (win_last) begin
            ctl_q       <= C_RESP;
            rsp_valid_q <= 1'b1;
            rsp_retry_q <= 1'b1;
            rsp_data_q  <= '0;
          end
        end
        C_RESP: begin
          if (rsp_ready) begin
            ctl_q       <= C_IDLE;
            rsp_valid_q <= 1'b0;
          end
        end
        default: ctl_q <= C_IDLE;
      endcase
    end
  end

  // delayed-read buffer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= B_FREE;
      baddr_q <= '0;
      bdata_q <= '0;
    end else begin
      case (buf_q)
        B_FREE: begin
          if (timeout) begin
            buf_q   <= B_WAITD;
            baddr_q <= raddr_q;
          end
        end
        B_WAITD: begin
          if (cpl_valid) begin
            buf_q   <= expire ? B_FREE : B_HELD;
            bdata_q <= cpl_data;
          end else if (expire) begin
            buf_q <= B_DRAIN;
          end
        end
        B_HELD: begin
          if (hit || expire) buf_q <= B_FREE;
        end
        B_DRAIN: begin
          if (cpl_valid) buf_q <= B_FREE;
        end
        default: buf_q <= B_FREE;
      endcase
    end
  end

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_retry) && $stable(rsp_data));

  p_busy_noaccept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rq_ready);

  p_timer_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> (timer_val == $past(life_q)) && rsp_valid && rsp_retry);

  p_hit_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (buf_q == B_FREE) && rsp_valid && !rsp_retry);

  p_foreign_retry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (buf_q != B_FREE) && !hit |=> rsp_valid && rsp_retry);

  p_expire_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_q == B_HELD) && expire |=> (buf_q == B_FREE));

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_q == B_DRAIN) && !cpl_valid |=> (buf_q == B_DRAIN));

endmodule

// File: tb/drl_delayed_read_tb.sv
module drl_delayed_read_tb_top;

  localparam int DL = 16;
  localparam logic [31:0] KEY = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rq_valid = 1'b0;
  logic        rq_ready;
  logic [31:0] rq_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_retry;
  logic [31:0] rsp_data;
  logic        fch_valid;
  logic        fch_ready = 1'b0;
  logic [31:0] fch_addr;
  logic        cpl_valid = 1'b0;
  logic [31:0] cpl_data = '0;
  logic        life_we = 1'b0;
  logic [15:0] life_wdata = '0;
  logic [15:0] life_q;

  always #2 clk = ~clk;

  drl_delayed_read dut_i (
    .clk(clk), .rst_n(rst_n),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_retry(rsp_retry), .rsp_data(rsp_data),
    .fch_valid(fch_valid), .fch_ready(fch_ready), .fch_addr(fch_addr),
    .cpl_valid(cpl_valid), .cpl_data(cpl_data),
    .life_we(life_we), .life_wdata(life_wdata), .life_q(life_q)
  );

  int    n_checks = 0;
  int    n_err = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  // ---------------- behavioural reference model ----------------
  int          m_ctl, m_b, m_w, m_t, m_life;
  bit          m_rv, m_rr, m_fv;
  logic [31:0] m_rd, m_fa, m_raddr, m_baddr, m_bdata;
  bit          s_acc, s_hit, s_tmo, s_run, s_exp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_b = 0; m_w = 0; m_t = 0; m_life = 32'h8000;
      m_rv = 0; m_rr = 0; m_fv = 0; m_rd = 0; m_fa = 0;
      m_raddr = 0; m_baddr = 0; m_bdata = 0;
    end else begin
      s_acc = rq_valid && (m_ctl == 0);
      s_hit = s_acc && (m_b == 2) && (rq_addr == m_baddr);
      s_tmo = (m_ctl == 1) && !cpl_valid && (m_w == DL - 1);
      s_run = (m_b == 1) || (m_b == 2);
      s_exp = s_run && (m_t == 0);
      if (s_tmo) m_t = m_life;
      else if (s_run && m_t != 0) m_t = m_t - 1;
      if (m_fv && fch_ready) m_fv = 0;
      case (m_ctl)
        0: if (s_acc) begin
             m_raddr = rq_addr;
             if (m_b == 0) begin m_ctl = 1; m_w = 0; m_fv = 1; m_fa = rq_addr; end
             else begin m_ctl = 2; m_rv = 1; m_rr = !s_hit; m_rd = s_hit ? m_bdata : 32'd0; end
           end
        1: if (cpl_valid) begin m_ctl = 2; m_rv = 1; m_rr = 0; m_rd = cpl_data; end
           else if (m_w == DL - 1) begin m_ctl = 2; m_rv = 1; m_rr = 1; m_rd = 0; end
           else m_w = m_w + 1;
        default: if (rsp_ready) begin m_ctl = 0; m_rv = 0; end
      endcase
      case (m_b)
        0: if (s_tmo) begin m_b = 1; m_baddr = m_raddr; end
        1: if (cpl_valid) begin m_b = s_exp ? 0 : 2; m_bdata = cpl_data; end
           else if (s_exp) m_b = 3;
        2: if (s_hit || s_exp) m_b = 0;
        default: if (cpl_valid) m_b = 0;
      endcase
      if (life_we) m_life = life_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks++;
      if (rq_ready !== (m_ctl == 0) || rsp_valid !== m_rv ||
          (m_rv && (rsp_retry !== m_rr || rsp_data !== m_rd)) ||
          fch_valid !== m_fv || (m_fv && fch_addr !== m_fa) ||
          life_q !== m_life[15:0]) begin
        n_err++;
        $display("FAIL %s model @%0t: rdy %b/%b rv %b/%b rr %b/%b rd %h/%h fv %b/%b fa %h/%h life %h/%h",
                 cur_tag, $time, rq_ready, (m_ctl == 0), rsp_valid, m_rv, rsp_retry, m_rr,
                 rsp_data, m_rd, fch_valid, m_fv, fch_addr, m_fa, life_q, m_life[15:0]);
      end
    end
  end

  // ---------------- fetch responder ----------------
  int          rdy_delay = 0;
  int          cpl_delay = 3;
  int          fcount = 0;
  logic [31:0] last_fa = '0;

  initial begin : responder
    forever begin
      @(negedge clk);
      if (fch_valid) begin
        for (int i = 0; i < rdy_delay; i++) @(negedge clk);
        fch_ready = 1'b1;
        last_fa = fch_addr;
        fcount++;
        @(negedge clk);
        fch_ready = 1'b0;
        if (cpl_delay > 0) begin
          for (int i = 1; i < cpl_delay; i++) @(negedge clk);
          cpl_valid = 1'b1;
          cpl_data = last_fa ^ KEY;
          @(negedge clk);
          cpl_valid = 1'b0;
        end
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send_cpl(input logic [31:0] d);
    @(negedge clk);
    cpl_valid = 1'b1;
    cpl_data = d;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic write_life(input logic [15:0] v);
    @(negedge clk);
    life_we = 1'b1;
    life_wdata = v;
    @(negedge clk);
    life_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read(input logic [31:0] a, input int hold,
                         output logic r, output logic [31:0] d, output int lat);
    @(negedge clk);
    rq_valid = 1'b1;
    rq_addr = a;
    while (!rq_ready) @(negedge clk);
    if (hold > 0) rsp_ready = 1'b0;
    @(negedge clk);
    rq_valid = 1'b0;
    lat = 1;
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    r = rsp_retry;
    d = rsp_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R10", "response held under back-pressure", {rsp_valid, rsp_retry, rq_ready}, {1'b1, r, 1'b0});
      chk("R10", "data stable under back-pressure", rsp_data, d);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // ---------------- scenarios ----------------
  initial begin : main
    logic        r;
    logic [31:0] d;
    int          lat;
    int          fc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cur_tag = "R1";
    chk("R1", "reset lifetime", {16'd0, life_q}, 32'h8000);
    chk("R1", "reset ready/valid", {rq_ready, rsp_valid, fch_valid}, 3'b100);
    write_life(16'd20);
    chk("R1", "lifetime write", {16'd0, life_q}, 32'd20);

    cur_tag = "R2";
    rdy_delay = 2; cpl_delay = 3;
    do_read(32'h100, 0, r, d, lat);
    chk("R2", "fetch address", last_fa, 32'h100);
    chk("R2", "latency with slow fetch ready", lat, 7);
    chk("R3", "fast read data", {31'd0, r}, 0);
    chk("R3", "fast read value", d, 32'h100 ^ KEY);

    cur_tag = "R3";
    rdy_delay = 0; cpl_delay = 15;
    do_read(32'h140, 0, r, d, lat);
    chk("R3", "completion in last window cycle", {31'd0, r}, 0);
    chk("R3", "last-cycle latency", lat, 17);
    chk("R3", "last-cycle data", d, 32'h140 ^ KEY);

    cur_tag = "R4";
    cpl_delay = 16;
    do_read(32'h180, 0, r, d, lat);
    chk("R4", "retry after window", {31'd0, r}, 1);
    chk("R4", "retry latency", lat, 17);
    chk("R4", "retry data zero", d, 0);
    cur_tag = "R6";
    fc = fcount;
    do_read(32'h200, 0, r, d, lat);
    chk("R6", "foreign address retried", {31'd0, r}, 1);
    chk("R6", "foreign address no fetch", fcount, fc);
    cur_tag = "R5";
    do_read(32'h180, 0, r, d, lat);
    chk("R5", "held data returned", {31'd0, r}, 0);
    chk("R5", "held data value", d, 32'h180 ^ KEY);
    chk("R5", "held data latency", lat, 1);
    chk("R5", "held data no fetch", fcount, fc);
    cpl_delay = 3;
    do_read(32'h180, 0, r, d, lat);
    chk("R5", "buffer freed after hit", fcount, fc + 1);
    chk("R5", "refetch data", {31'd0, r}, 0);

    cur_tag = "R7";
    cpl_delay = 0;
    do_read(32'h300, 0, r, d, lat);
    chk("R7", "no completion retried", {31'd0, r}, 1);
    fc = fcount;
    do_read(32'h300, 0, r, d, lat);
    chk("R7", "same address before data retried", {31'd0, r}, 1);
    chk("R7", "same address no fetch", fcount, fc);
    do_read(32'h304, 0, r, d, lat);
    chk("R6", "foreign address while waiting retried", {31'd0, r}, 1);
    send_cpl(32'h300 ^ KEY);
    do_read(32'h300, 0, r, d, lat);
    chk("R5", "late data served", d, 32'h300 ^ KEY);
    chk("R5", "late data not retry", {31'd0, r}, 0);

    cur_tag = "R8";
    write_life(16'd5);
    cpl_delay = 16;
    do_read(32'h400, 0, r, d, lat);
    chk("R8", "retry before hold", {31'd0, r}, 1);
    idle(10);
    cpl_delay = 3;
    fc = fcount;
    do_read(32'h400, 0, r, d, lat);
    chk("R8", "expired data refetched", fcount, fc + 1);
    chk("R8", "refetch returns data", {31'd0, r}, 0);

    write_life(16'd0);
    cpl_delay = 16;
    do_read(32'h480, 0, r, d, lat);
    chk("R8", "zero lifetime retry", {31'd0, r}, 1);
    cpl_delay = 3;
    fc = fcount;
    do_read(32'h480, 0, r, d, lat);
    chk("R8", "zero lifetime frees next clock", fcount, fc + 1);
    chk("R8", "zero lifetime refetch data", d, 32'h480 ^ KEY);

    cur_tag = "R9";
    write_life(16'd2);
    cpl_delay = 0;
    do_read(32'h500, 0, r, d, lat);
    idle(4);
    fc = fcount;
    do_read(32'h500, 0, r, d, lat);
    chk("R9", "drain retries same address", {31'd0, r}, 1);
    do_read(32'h504, 0, r, d, lat);
    chk("R9", "drain retries other address", {31'd0, r}, 1);
    chk("R9", "drain issues no fetch", fcount, fc);
    send_cpl(32'hDEAD_BEEF);
    cpl_delay = 3;
    do_read(32'h500, 0, r, d, lat);
    chk("R9", "stale completion discarded", d, 32'h500 ^ KEY);
    chk("R9", "fetch after drain", fcount, fc + 1);

    cur_tag = "R10";
    write_life(16'd20);
    do_read(32'h600, 4, r, d, lat);
    chk("R10", "back-pressured data", d, 32'h600 ^ KEY);

    cur_tag = "R11";
    write_life(16'd30);
    cpl_delay = 16;
    do_read(32'h700, 0, r, d, lat);
    write_life(16'd1);
    chk("R11", "new lifetime visible", {16'd0, life_q}, 32'd1);
    idle(5);
    do_read(32'h700, 0, r, d, lat);
    chk("R11", "running hold unaffected", {31'd0, r}, 0);
    chk("R11", "running hold data", d, 32'h700 ^ KEY);

    idle(3);
    finish_run();
  end

endmodule